// File: doc/BRIEF.md
# Twelve-Step Decimal Hour Counter

This block counts upward through the decimal values 01 to 12 and then starts again at 01, as an hour counter on a clock face does. The value is kept as two decimal digits in separate decade stages. The units stage steps once for each enabled count-clock edge. The tens stage steps when the units stage passes 9.

A two-digit terminal detect, rather than a plain modulo wrap, restarts the count. When the counter holds 12, the next enabled edge loads 01 in a single clock, so no out-of-range value ever appears. Each digit also goes through its own decoder, which drives an active-low seven-segment pattern. A one-cycle wrap output marks each completed twelve-step cycle and can feed a following stage, for example an AM/PM toggle.

Top module: `hour12_counter`

## Requirements
- R1: On each rising clock edge with en=1 and rst=0, the value (tens*10+units) goes up by one, through 01, 02, … 11, 12.
- R2: units_bcd always holds 0 to 9, and tens_bcd always holds 0 or 1.
- R3: When the value is 12 and an enabled edge occurs, the next value is tens=0, units=1.
- R4: With en=0 and rst=0, an edge leaves both digits unchanged and wrap low.
- R5: When units is 9 and an enabled edge occurs, units becomes 0 and tens goes up by one, so 09 is followed by 10.
- R6: rst=1 at a rising edge sets the value to 01 (tens=0, units=1) and wrap to 0, whatever en is.
- R7: wrap is 1 only in the cycle after the enabled edge that took 12 to 01. It is never high for two cycles in a row.
- R8: Each segment output is active-low, with bit 6 = g down to bit 0 = a. Digits 0..9 map to 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous reset to 01, active high |
| en | input | 1 | Count enable |
| units_bcd | output | 4 | Units digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| units_seg | output | 7 | Units segment pattern, g..a, active low |
| tens_seg | output | 7 | Tens segment pattern, g..a, active low |
| wrap | output | 1 | One-cycle pulse after 12 becomes 01 |

## Verification
The digits and wrap are registers, so each is due one edge after the stimulus that caused it. The segment patterns are combinational from those registers and are valid in the same cycle as the digits. The bench changes inputs on the falling edge and samples one time unit after the next rising edge. As a result, every check looks at exactly one edge's effect. The full-cycle walk compares the outputs against a value modelled in the bench, so the carry out of 09 and the restart after 12 are both checked at the edge where they happen.

// File: rtl/hour12_pkg.sv
package hour12_pkg;
   localparam int DIGIT_W = 4;
   localparam int SEG_W   = 7;
   typedef logic [DIGIT_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/decade_stage.sv
module decade_stage
   import hour12_pkg::*;
#(
   parameter int MAX_DIGIT = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  bcd_t load_val,
   input  logic inc,
   output bcd_t digit,
   output logic at_max
);
   localparam bcd_t MAX_V = bcd_t'(MAX_DIGIT);

   initial assert (MAX_DIGIT >= 1 && MAX_DIGIT <= 9)
      else $error("decade_stage: MAX_DIGIT out of range");

   assign at_max = (digit == MAX_V);

   always_ff @(posedge clk) begin
      if (rst || load)
         digit <= load_val;
      else if (inc)
         digit <= at_max ? '0 : digit + bcd_t'(1);
   end

   // R2: the stage never leaves the decimal range
   a_r2_digit_bcd: assert property (@(posedge clk) disable iff (rst)
      digit <= MAX_V);
endmodule

// File: rtl/seg7_decode.sv
module seg7_decode
   import hour12_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  bcd_t digit,
   output seg_t seg
);
   seg_t lo_pat;

   always_comb begin
      unique case (digit)
         4'd0:    lo_pat = 7'b1000000;
         4'd1:    lo_pat = 7'b1111001;
         4'd2:    lo_pat = 7'b0100100;
         4'd3:    lo_pat = 7'b0110000;
         4'd4:    lo_pat = 7'b0011001;
         4'd5:    lo_pat = 7'b0010010;
         4'd6:    lo_pat = 7'b0000010;
         4'd7:    lo_pat = 7'b1111000;
         4'd8:    lo_pat = 7'b0000000;
         4'd9:    lo_pat = 7'b0010000;
         default: lo_pat = 7'b1111111;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign seg = lo_pat;
      end else begin : g_high
         assign seg = ~lo_pat;
      end
   endgenerate
endmodule

// File: rtl/hour12_counter.sv
module hour12_counter
   import hour12_pkg::*;
#(
   parameter int FIRST_UNITS = 1,
   parameter int LAST_TENS   = 1,
   parameter int LAST_UNITS  = 2,
   parameter bit SEG_LOW     = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   output logic [3:0] units_bcd,
   output logic [3:0] tens_bcd,
   output logic [6:0] units_seg,
   output logic [6:0] tens_seg,
   output logic       wrap
);
   localparam bcd_t FIRST_U = bcd_t'(FIRST_UNITS);
   localparam bcd_t LAST_T  = bcd_t'(LAST_TENS);
   localparam bcd_t LAST_U  = bcd_t'(LAST_UNITS);

   initial begin
      assert (FIRST_UNITS >= 0 && FIRST_UNITS <= 9) else $error("FIRST_UNITS range");
      assert (LAST_UNITS >= 0 && LAST_UNITS <= 9) else $error("LAST_UNITS range");
      assert (LAST_TENS >= 1 && LAST_TENS <= 9) else $error("LAST_TENS range");
   end

   bcd_t units_q, tens_q;
   logic units_nine, tens_top;
   logic term, restart;

   assign term    = (tens_q == LAST_T) && (units_q == LAST_U);
   assign restart = en && term;

   decade_stage #(.MAX_DIGIT(9)) u_units (
      .clk(clk), .rst(rst), .load(restart), .load_val(FIRST_U),
      .inc(en), .digit(units_q), .at_max(units_nine)
   );

   decade_stage #(.MAX_DIGIT(LAST_TENS)) u_tens (
      .clk(clk), .rst(rst), .load(restart), .load_val('0),
      .inc(en && units_nine), .digit(tens_q), .at_max(tens_top)
   );

   always_ff @(posedge clk) begin
      if (rst) wrap <= 1'b0;
      else     wrap <= restart;
   end

   seg7_decode #(.ACTIVE_LOW(SEG_LOW)) u_seg_u (.digit(units_q), .seg(units_seg));
   seg7_decode #(.ACTIVE_LOW(SEG_LOW)) u_seg_t (.digit(tens_q),  .seg(tens_seg));

   assign units_bcd = units_q;
   assign tens_bcd  = tens_q;

   // R3: terminal value restarts at the first value
   a_r3_restart: assert property (@(posedge clk) disable iff (rst)
      (en && tens_bcd == LAST_T && units_bcd == LAST_U) |=> (tens_bcd == '0 && units_bcd == FIRST_U));
   // R4: disabled edges hold the value
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable({tens_bcd, units_bcd}) && !wrap));
   // R5: units carry into tens
   a_r5_carry: assert property (@(posedge clk) disable iff (rst)
      (en && units_bcd == 4'd9) |=> (units_bcd == '0 && tens_bcd == $past(tens_bcd) + 4'd1));
   // R7: wrap marks the first value and lasts one cycle
   a_r7_wrap_value: assert property (@(posedge clk) disable iff (rst)
      wrap |-> (tens_bcd == '0 && units_bcd == FIRST_U));
   a_r7_wrap_single: assert property (@(posedge clk) disable iff (rst)
      wrap |=> !wrap);
   // R2: tens stays within its range
   a_r2_tens_range: assert property (@(posedge clk) disable iff (rst)
      tens_bcd <= LAST_T);
endmodule

// File: tb/sim_hour12_counter.sv
module sim_hour12_counter;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 18;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [3:0] units_bcd, tens_bcd;
   logic [6:0] units_seg, tens_seg;
   logic wrap;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   hour12_counter u0 (
      .clk(clk), .rst(rst), .en(en),
      .units_bcd(units_bcd), .tens_bcd(tens_bcd),
      .units_seg(units_seg), .tens_seg(tens_seg), .wrap(wrap)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // vector: {rst, en, exp_tens[3:0], exp_units[3:0], exp_wrap}
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b1,1'b0,4'd0,4'd1,1'b0},
      {1'b0,1'b1,4'd0,4'd2,1'b0},
      {1'b0,1'b1,4'd0,4'd3,1'b0},
      {1'b0,1'b0,4'd0,4'd3,1'b0},
      {1'b0,1'b1,4'd0,4'd4,1'b0},
      {1'b0,1'b1,4'd0,4'd5,1'b0},
      {1'b0,1'b1,4'd0,4'd6,1'b0},
      {1'b0,1'b1,4'd0,4'd7,1'b0},
      {1'b0,1'b1,4'd0,4'd8,1'b0},
      {1'b0,1'b1,4'd0,4'd9,1'b0},
      {1'b0,1'b1,4'd1,4'd0,1'b0},
      {1'b0,1'b0,4'd1,4'd0,1'b0},
      {1'b0,1'b1,4'd1,4'd1,1'b0},
      {1'b0,1'b1,4'd1,4'd2,1'b0},
      {1'b0,1'b1,4'd0,4'd1,1'b1},
      {1'b0,1'b0,4'd0,4'd1,1'b0},
      {1'b0,1'b1,4'd0,4'd2,1'b0},
      {1'b1,1'b1,4'd0,4'd1,1'b0}
   };

   function automatic logic [6:0] exp_seg(input logic [3:0] d);
      case (d)
         4'd0: return 7'b1000000;
         4'd1: return 7'b1111001;
         4'd2: return 7'b0100100;
         4'd3: return 7'b0110000;
         4'd4: return 7'b0011001;
         4'd5: return 7'b0010010;
         4'd6: return 7'b0000010;
         4'd7: return 7'b1111000;
         4'd8: return 7'b0000000;
         4'd9: return 7'b0010000;
         default: return 7'b1111111;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string act, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic e);
      @(negedge clk);
      rst = r;
      en  = e;
      @(posedge clk);
      #1;
   endtask

   task automatic check_all(input logic [3:0] et, input logic [3:0] eu, input logic ew, input string req);
      chk(tens_bcd == et && units_bcd == eu, req,
          $sformatf("%0d%0d", tens_bcd, units_bcd), $sformatf("%0d%0d", et, eu));
      chk(wrap == ew, {req, "/R7 wrap"}, $sformatf("%0b", wrap), $sformatf("%0b", ew));
      chk(units_seg == exp_seg(eu) && tens_seg == exp_seg(et), "R8 segments",
          $sformatf("%b %b", tens_seg, units_seg),
          $sformatf("%b %b", exp_seg(et), exp_seg(eu)));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int val;
      // reset state (R6)
      step(1'b1, 1'b0);
      check_all(4'd0, 4'd1, 1'b0, "R6 reset state");

      // table walk: R1, R3, R4, R5, R6, R7
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][10], VEC[i][9]);
         check_all(VEC[i][8:5], VEC[i][4:1], VEC[i][0], $sformatf("R1/R3/R4/R5 vec%0d", i));
      end

      // three full cycles against a bench model (R1, R2, R3, R5, R7)
      val = 1;
      for (int c = 0; c < 36; c++) begin
         logic w;
         w = (val == 12);
         val = (val == 12) ? 1 : val + 1;
         step(1'b0, 1'b1);
         check_all(4'(val / 10), 4'(val % 10), w, "R1 model walk");
         chk(units_bcd <= 4'd9 && tens_bcd <= 4'd1, "R2 range",
             $sformatf("%0d%0d", tens_bcd, units_bcd), "<=19");
      end

      // R4: long hold at 12 with en low, then the restart
      repeat (11) step(1'b0, 1'b1);
      check_all(4'd1, 4'd2, 1'b0, "R1 reach 12");
      repeat (5) step(1'b0, 1'b0);
      check_all(4'd1, 4'd2, 1'b0, "R4 hold at 12");
      step(1'b0, 1'b1);
      check_all(4'd0, 4'd1, 1'b1, "R3 restart after hold");
      step(1'b0, 1'b0);
      check_all(4'd0, 4'd1, 1'b0, "R7 single pulse");

      // R6: reset from 10 with en high lands on 01 and no wrap
      repeat (9) step(1'b0, 1'b1);
      check_all(4'd1, 4'd0, 1'b0, "R5 09 to 10");
      step(1'b1, 1'b1);
      check_all(4'd0, 4'd1, 1'b0, "R6 reset mid-count");

      // R6: reset at 12 with en high gives no wrap pulse
      repeat (11) step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      check_all(4'd0, 4'd1, 1'b0, "R6 reset at 12");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule